// File: doc/BRIEF.md
# Instruction byte prefetch queue

This block keeps a small store of instruction bytes ready for an execution unit. It fetches bytes from a slow, byte-wide memory bus at rising addresses and works on its own: the consumer never asks for a fetch. The consumer takes bytes from the head of the store through a valid/ready handshake. It sees only a stream of bytes in program order and never sees the bus traffic behind it.

When the execution unit changes the program flow with a jump, call or return, it raises a flush together with the target address. The store is emptied and fetching restarts at the target. A fetch that is already on the bus is not aborted. It runs to its end, its byte is thrown away, and the next fetch goes to the target. Each fetch holds the bus for a fixed number of cycles. A fetch starts only when the bytes already stored plus the one in flight leave room, so a returning byte always finds a free slot.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is high, `out_valid_o` and `bus_busy_o` are low. In the first cycle after reset is released, a fetch is on the bus with `bus_addr_o` equal to the parameter `RESET_VEC`.
- R2: A fetch keeps `bus_busy_o` high for exactly `BUS_CYCLES` (4) cycles, with `bus_addr_o` stable throughout. `bus_rdata_i` is sampled at the clock edge that ends the last of those cycles.
- R3: The queue never holds more than `DEPTH` (4) bytes. When the stored bytes plus the byte in flight reach `DEPTH`, no new fetch starts and `bus_busy_o` goes low.
- R4: While there is room, fetching continues without any request from the consumer. A new fetch starts in the cycle right after the previous one ends, so there is no idle bus cycle between them.
- R5: Bytes reach `out_byte_o` in program order. Consecutive bytes come from consecutive addresses, and the address wraps modulo 2^`ADDR_W`.
- R6: A byte leaves the queue only at a clock edge where `out_valid_o` and `out_ready_i` are both high. While `out_ready_i` is low, the head byte stays presented and does not change.
- R7: A flush empties the queue, so `out_valid_o` is low in the next cycle. The next byte delivered is the byte at `flush_addr_i`, followed by the bytes at the addresses after it.
- R8: A flush that arrives during a fetch lets that fetch finish, with `bus_busy_o` high and `bus_addr_o` unchanged, and discards its byte. The fetch at the target starts in the cycle after the old fetch ends.
- R9: A byte that completes into an empty queue is presented in the very next cycle. When a byte arrives and another is removed at the same edge, the occupancy stays consistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Control transfer: empty the queue and redirect fetching |
| flush_addr_i | input | ADDR_W | Target address that goes with `flush_i` |
| out_valid_o | output | 1 | A head byte is available |
| out_byte_o | output | 8 | Head byte |
| out_ready_i | input | 1 | Consumer accepts the head byte |
| bus_busy_o | output | 1 | A bus fetch is in progress |
| bus_addr_o | output | ADDR_W | Address of the fetch in progress |
| bus_rdata_i | input | 8 | Byte returned by memory, valid in the last fetch cycle |

## Verification
If the occupancy count goes wrong, the fault shows at the ports on the next edge. The bus either stays busy while the queue is full or idles while there is room, and `out_valid_o` disagrees with the number of bytes delivered. A wrong fetch address or a missed drop after a flush shows up as a wrong byte value the first time that byte reaches the head. That takes at most one fetch period plus the queue depth in cycles. The bench therefore checks the bus strobe, the bus address, the valid flag and the head byte on every cycle against a behavioural model. It also drives flushes at the start, middle and end of a fetch.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef logic [7:0] byte_t;

  // width for a counter that must reach n inclusive
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo
  import pfq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          push,
  input  byte_t                         wdata,
  input  logic                          pop,
  output byte_t                         head_o,
  output logic [cnt_width(DEPTH)-1:0]   count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = cnt_width(DEPTH);

  byte_t             mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_q;

  // storage without reset so it maps to distributed or block memory
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  assert_full_push_R3: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_W'(DEPTH) && !clr) |-> !(push && !pop));

  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0));
endmodule

// File: rtl/pfq_bus.sv
module pfq_bus #(
  parameter int ADDR_W     = 16,
  parameter int BUS_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              flush,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              drop_o
);
  localparam int TMR_W = (BUS_CYCLES > 1) ? $clog2(BUS_CYCLES) : 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(BUS_CYCLES - 1);

  logic              busy_q, drop_q;
  logic [TMR_W-1:0]  timer_q;
  logic [ADDR_W-1:0] addr_q;

  assign done_o = busy_q && (timer_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
      addr_q  <= '0;
    end else if (busy_q && !done_o) begin
      timer_q <= timer_q + 1'b1;
    end else if (start) begin
      busy_q  <= 1'b1;
      timer_q <= '0;
      addr_q  <= start_addr;
    end else begin
      busy_q  <= 1'b0;
    end
  end

  // a redirect during a fetch marks its byte for discard
  always_ff @(posedge clk) begin
    if (rst)                  drop_q <= 1'b0;
    else if (done_o)          drop_q <= 1'b0;
    else if (flush && busy_q) drop_q <= 1'b1;
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
  assign drop_o = drop_q;

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_o) |=> (busy_q && $stable(addr_q)));

  assert_flush_no_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (flush && busy_q && !done_o) |=> (busy_q && drop_q));
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DEPTH      = 4,
  parameter int          BUS_CYCLES = 4,
  parameter logic [15:0] RESET_VEC  = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              out_valid_o,
  output logic [7:0]        out_byte_o,
  input  logic              out_ready_i,
  output logic              bus_busy_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic [7:0]        bus_rdata_i
);
  localparam int CNT_W = cnt_width(DEPTH);
  localparam int CALC_W = CNT_W + 1;

  logic [CNT_W-1:0]  count;
  logic [CALC_W-1:0] next_cnt;
  logic              done, drop, push, pop, start;
  logic [ADDR_W-1:0] fetch_addr_q, fetch_addr_nx;
  byte_t             head;

  assign out_valid_o = (count != '0);
  assign pop  = out_valid_o && out_ready_i && !flush_i;
  assign push = done && !drop && !flush_i;

  assign next_cnt = flush_i ? '0
                  : CALC_W'(count) + CALC_W'(push) - CALC_W'(pop);
  // the in-flight byte is counted once the fetch starts, so room is checked here
  assign start = (next_cnt < CALC_W'(DEPTH));

  always_comb begin
    if (flush_i)   fetch_addr_nx = flush_addr_i;
    else if (push) fetch_addr_nx = fetch_addr_q + 1'b1;
    else           fetch_addr_nx = fetch_addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) fetch_addr_q <= ADDR_W'(RESET_VEC);
    else     fetch_addr_q <= fetch_addr_nx;
  end

  pfq_bus #(.ADDR_W(ADDR_W), .BUS_CYCLES(BUS_CYCLES)) u_bus (
    .clk(clk), .rst(rst), .start(start), .start_addr(fetch_addr_nx),
    .flush(flush_i), .busy_o(bus_busy_o), .addr_o(bus_addr_o),
    .done_o(done), .drop_o(drop)
  );

  pfq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(flush_i), .push(push), .wdata(bus_rdata_i),
    .pop(pop), .head_o(head), .count_o(count)
  );

  assign out_byte_o = head;

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !out_valid_o);

  assert_land_visible_R9: assert property (@(posedge clk) disable iff (rst)
    push |=> out_valid_o);
endmodule

// File: tb/prefetch_queue_test.sv
`timescale 1ns/1ps
module prefetch_queue_test;
  localparam int AW = 16;
  localparam int DEPTH = 4;
  localparam int BC = 4;
  localparam logic [15:0] RV = 16'hFFF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic ready = 1'b0;
  logic out_valid, bus_busy;
  logic [7:0] out_byte, bus_rdata;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return 8'((a * 13) ^ (a >> 5)) + 8'd7;
  endfunction

  assign bus_rdata = mem_byte(bus_addr);

  prefetch_queue #(.ADDR_W(AW), .DEPTH(DEPTH), .BUS_CYCLES(BC), .RESET_VEC(RV)) uut (
    .clk(clk), .rst(rst), .flush_i(flush), .flush_addr_i(flush_addr),
    .out_valid_o(out_valid), .out_byte_o(out_byte), .out_ready_i(ready),
    .bus_busy_o(bus_busy), .bus_addr_o(bus_addr), .bus_rdata_i(bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int mq[$];
  bit m_busy = 0, m_drop = 0;
  int m_timer = 0, m_baddr = 0, m_faddr = RV;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_busy = 0; m_drop = 0; m_timer = 0; m_baddr = 0; m_faddr = RV;
    end else begin : step
      bit done, take, land;
      int nb;
      done = m_busy && (m_timer == BC - 1);
      take = (mq.size() > 0) && ready && !flush;   // R6: removal needs valid and ready
      land = done && !m_drop && !flush;
      nb = mem_byte(AW'(m_baddr));
      if (flush) mq.delete();
      else begin
        if (take) void'(mq.pop_front());
        if (land) mq.push_back(nb);
      end
      if (flush) m_faddr = flush_addr;
      else if (land) m_faddr = (m_faddr + 1) & 16'hFFFF;
      if (done) m_drop = 0;
      else if (flush && m_busy) m_drop = 1;
      if (m_busy && !done) m_timer++;
      else if (mq.size() < DEPTH) begin m_busy = 1; m_timer = 0; m_baddr = m_faddr; end
      else m_busy = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(out_valid == (mq.size() != 0), "R9", "valid vs model", out_valid, mq.size() != 0);
      if (mq.size() != 0) chk(out_byte == mq[0], "R5", "head byte vs model", out_byte, mq[0]);
      chk(bus_busy == m_busy, "R4", "bus busy vs model", bus_busy, m_busy);
      if (m_busy) chk(bus_addr == AW'(m_baddr), "R2", "bus addr vs model", bus_addr, m_baddr);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int n;
    logic [AW-1:0] a0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", "valid in reset", out_valid, 0);
    chk(!bus_busy, "R1", "bus busy in reset", bus_busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_busy, "R1", "fetch starts after reset", bus_busy, 1);
    chk(bus_addr == RV, "R1", "first fetch address", bus_addr, RV);
    n = 1;
    while (!out_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 5, "R2", "cycles to first byte", n, 5);
    chk(out_byte == mem_byte(RV), "R9", "first byte straight through", out_byte, mem_byte(RV));

    repeat (30) @(negedge clk);
    chk(!bus_busy, "R3", "bus idle when full", bus_busy, 0);
    chk(out_byte == mem_byte(RV), "R6", "head held while not ready", out_byte, mem_byte(RV));
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk(bus_busy && bus_addr == RV + 16'd4, "R4", "refetch after one removal",
        bus_addr, RV + 16'd4);
    chk(out_byte == mem_byte(RV + 16'd1), "R5", "next byte in order",
        out_byte, mem_byte(RV + 16'd1));

    ready = 1'b1;
    repeat (40) @(negedge clk);
    a0 = bus_addr;
    n = 0;
    while (bus_addr == a0 && n < 10) begin @(negedge clk); n++; end
    a0 = bus_addr;
    flush = 1'b1; flush_addr = 16'h1234;
    @(negedge clk);
    flush = 1'b0;
    chk(!out_valid, "R7", "queue empty after flush", out_valid, 0);
    chk(bus_busy && bus_addr == a0, "R8", "in-flight fetch continues", bus_addr, a0);
    n = 0;
    while (!out_valid && n < 20) begin @(negedge clk); n++; end
    chk(out_byte == mem_byte(16'h1234), "R7", "first byte from target",
        out_byte, mem_byte(16'h1234));

    for (int i = 0; i < 3000; i++) begin
      ready = ($urandom_range(0, 9) < 7);
      flush = ($urandom_range(0, 49) == 0);
      flush_addr = AW'($urandom);
      @(negedge clk);
    end
    flush = 1'b0;
    repeat (10) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule